// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block sits in the decode stage of an in-order pipeline and settles control flow there, without waiting for execute. It compares the two branch operands, computes the next-PC target for conditional branches, PC-relative jumps and register-indirect jumps, and raises a redirect flag whenever the fetch path must leave its sequential course.

Operands may still be in flight in later stages, so the block forwards them itself. For branch comparisons, it looks at the two stages behind execute. For the indirect-jump base, it also looks at the execute stage. Each source has a fixed priority, and a source is used only when it really writes a non-zero register.

The unit is purely combinational. It has no state, so it has no states or transitions to name. Pipeline flushing, stall generation and the register file belong to the surrounding logic.

Top module: `bju_resolve`

## Requirements
- R1: Each branch operand (`opnd1_o` from `rs1_i`, `opnd2_o` from `rs2_i`) is selected in this order:
  - the EX/MEM result if that stage's destination matches;
  - otherwise the MEM/WB result if that stage's destination matches;
  - otherwise the register-file read value.
  
  A matching EX-stage destination never affects the branch operands.
- R2: A stage counts as matching only when its write-enable is 1 and its destination index is non-zero. A stage with write-enable 0 or destination 0 is never forwarded, whatever its result.
- R3: The register-indirect jump base is selected in this order:
  - the EX result if that stage matches `rs1_i`;
  - otherwise the EX/MEM result;
  - otherwise the MEM/WB result;
  - otherwise `rf_rdata1_i`.
- R4: When `jump_type_i` is 1 (PC-relative jump), `target_o` is `pc_i + imm_i`, modulo 2^XLEN.
- R5: When `jump_type_i` is 2 (register-indirect jump), `target_o` is the jump base plus `imm_i`, with bit 0 forced to 0.
- R6: When `jump_type_i` is 0 or 3, `target_o` is `pc_i + imm_i`.
- R7: The branch condition comes from `funct3_i`:
  - 000 taken on equal;
  - 001 taken on not equal;
  - 100 taken on signed less-than;
  - 101 taken on signed greater-or-equal;
  - 110 taken on unsigned less-than;
  - 111 taken on unsigned greater-or-equal.
  
  All comparisons use the forwarded branch operands.
- R8: `funct3_i` values 010 and 011 never make a branch taken.
- R9: A branch can be taken only while `is_branch_i` is 1. `redirect_o` is 1 exactly when a branch is taken or `jump_type_i` is non-zero. With all inputs at zero, `redirect_o` is 0 and `target_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | XLEN | PC of the decoded instruction |
| imm_i | input | XLEN | Sign-extended immediate |
| funct3_i | input | 3 | Branch condition code |
| jump_type_i | input | 2 | 0 none/branch, 1 PC-relative jump, 2 register-indirect jump, 3 treated as PC-relative |
| is_branch_i | input | 1 | Instruction is a conditional branch |
| rs1_i | input | REGW | First source register index |
| rs2_i | input | REGW | Second source register index |
| rf_rdata1_i | input | XLEN | Register-file value for rs1 |
| rf_rdata2_i | input | XLEN | Register-file value for rs2 |
| ex_rd_i | input | REGW | EX-stage destination index |
| ex_we_i | input | 1 | EX-stage register write enable |
| ex_result_i | input | XLEN | EX-stage result |
| exm_rd_i | input | REGW | EX/MEM destination index |
| exm_we_i | input | 1 | EX/MEM register write enable |
| exm_result_i | input | XLEN | EX/MEM result |
| mwb_rd_i | input | REGW | MEM/WB destination index |
| mwb_we_i | input | 1 | MEM/WB register write enable |
| mwb_result_i | input | XLEN | MEM/WB result |
| target_o | output | XLEN | Next-PC target |
| redirect_o | output | 1 | PC must be redirected |
| opnd1_o | output | XLEN | Resolved first branch operand |
| opnd2_o | output | XLEN | Resolved second branch operand |

## Verification
The hardest situation to reach is several stages claiming the same source register at once. In that case only the priority order decides the result, and a stage with a zero destination or a cleared write-enable must lose even though its index matches. The bench reaches this with a full sweep over all three stages. Each stage's enable and destination are swept over zero, rs1 and rs2, with every stage carrying a distinct result. Both operands and the indirect-jump base are checked in every combination. A second sweep covers all condition codes, jump types and branch flags against boundary operand pairs around the signed and unsigned limits.

// File: rtl/bju_pkg.sv
package bju_pkg;

    typedef enum logic [1:0] {
        JT_NONE  = 2'd0,
        JT_PCREL = 2'd1,
        JT_REG   = 2'd2,
        JT_RSVD  = 2'd3
    } jump_kind_e;

    typedef enum logic [2:0] {
        CND_EQ  = 3'b000,
        CND_NE  = 3'b001,
        CND_LT  = 3'b100,
        CND_GE  = 3'b101,
        CND_LTU = 3'b110,
        CND_GEU = 3'b111
    } cond_code_e;

endpackage

// File: rtl/bju_fwd_sel.sv
module bju_fwd_sel #(
    parameter int XLEN = 32,
    parameter int REGW = 5,
    parameter int NSRC = 2
) (
    input  logic [REGW-1:0]            rs_i,
    input  logic [NSRC-1:0][REGW-1:0]  rd_i,
    input  logic [NSRC-1:0]            we_i,
    input  logic [NSRC-1:0][XLEN-1:0]  data_i,
    input  logic [XLEN-1:0]            rf_i,
    output logic [XLEN-1:0]            opnd_o,
    output logic [NSRC-1:0]            hit_o
);

    // Index 0 carries the highest priority.
    for (genvar g = 0; g < NSRC; g++) begin : g_hit
        assign hit_o[g] = we_i[g] && (rd_i[g] != '0) && (rd_i[g] == rs_i);
    end

    always_comb begin
        opnd_o = rf_i;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (hit_o[k]) opnd_o = data_i[k];
        end
    end

    always_comb begin
        if (!$isunknown({rs_i, rd_i, we_i, data_i, rf_i})) begin
            // R2
            no_fwd_chk: assert (hit_o != '0 || opnd_o == rf_i)
                else $error("operand not from register file without a hit");
            // R1
            top_prio_chk: assert (!hit_o[0] || opnd_o == data_i[0])
                else $error("highest-priority hit not selected");
        end
    end

endmodule

// File: rtl/bju_cond.sv
module bju_cond
    import bju_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [2:0]      funct3_i,
    input  logic            is_branch_i,
    output logic            taken_o
);

    logic eq, lt_s, lt_u, cond;

    assign eq   = (a_i == b_i);
    assign lt_s = ($signed(a_i) < $signed(b_i));
    assign lt_u = (a_i < b_i);

    always_comb begin
        unique case (funct3_i)
            CND_EQ:  cond = eq;
            CND_NE:  cond = !eq;
            CND_LT:  cond = lt_s;
            CND_GE:  cond = !lt_s;
            CND_LTU: cond = lt_u;
            CND_GEU: cond = !lt_u;
            default: cond = 1'b0;
        endcase
    end

    assign taken_o = is_branch_i && cond;

    always_comb begin
        if (!$isunknown({a_i, b_i, funct3_i, is_branch_i})) begin
            // R9
            gate_chk: assert (!taken_o || is_branch_i)
                else $error("taken without branch flag");
            // R8
            rsvd_cond_chk: assert (!(funct3_i[2:1] == 2'b01) || !taken_o)
                else $error("reserved condition taken");
            // R7
            eq_cond_chk: assert (!(taken_o && funct3_i == CND_EQ) || a_i == b_i)
                else $error("equal branch taken on different operands");
        end
    end

endmodule

// File: rtl/bju_target.sv
module bju_target
    import bju_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] imm_i,
    input  logic [XLEN-1:0] base_i,
    input  logic [1:0]      jump_type_i,
    output logic [XLEN-1:0] target_o
);

    logic [XLEN-1:0] pc_sum, reg_sum;

    assign pc_sum  = pc_i + imm_i;
    assign reg_sum = base_i + imm_i;

    always_comb begin
        unique case (jump_type_i)
            JT_REG:  target_o = {reg_sum[XLEN-1:1], 1'b0};
            default: target_o = pc_sum;
        endcase
    end

    always_comb begin
        if (!$isunknown({pc_i, imm_i, base_i, jump_type_i})) begin
            // R5
            align_chk: assert (jump_type_i != JT_REG || target_o[0] == 1'b0)
                else $error("indirect target bit 0 set");
        end
    end

endmodule

// File: rtl/bju_resolve.sv
module bju_resolve
    import bju_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int REGW = 5
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] imm_i,
    input  logic [2:0]      funct3_i,
    input  logic [1:0]      jump_type_i,
    input  logic            is_branch_i,
    input  logic [REGW-1:0] rs1_i,
    input  logic [REGW-1:0] rs2_i,
    input  logic [XLEN-1:0] rf_rdata1_i,
    input  logic [XLEN-1:0] rf_rdata2_i,
    input  logic [REGW-1:0] ex_rd_i,
    input  logic            ex_we_i,
    input  logic [XLEN-1:0] ex_result_i,
    input  logic [REGW-1:0] exm_rd_i,
    input  logic            exm_we_i,
    input  logic [XLEN-1:0] exm_result_i,
    input  logic [REGW-1:0] mwb_rd_i,
    input  logic            mwb_we_i,
    input  logic [XLEN-1:0] mwb_result_i,
    output logic [XLEN-1:0] target_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] opnd1_o,
    output logic [XLEN-1:0] opnd2_o
);

    localparam int NBR  = 2;   // branch operand sources
    localparam int NJMP = 3;   // indirect-jump base sources

    logic [NBR-1:0][REGW-1:0]  br_rd;
    logic [NBR-1:0]            br_we;
    logic [NBR-1:0][XLEN-1:0]  br_data;
    logic [NJMP-1:0][REGW-1:0] jb_rd;
    logic [NJMP-1:0]           jb_we;
    logic [NJMP-1:0][XLEN-1:0] jb_data;
    logic [NBR-1:0]            hit1, hit2;
    logic [NJMP-1:0]           hitj;
    logic [XLEN-1:0]           jbase;
    logic                      taken;

    assign br_rd   = {mwb_rd_i, exm_rd_i};
    assign br_we   = {mwb_we_i, exm_we_i};
    assign br_data = {mwb_result_i, exm_result_i};
    assign jb_rd   = {mwb_rd_i, exm_rd_i, ex_rd_i};
    assign jb_we   = {mwb_we_i, exm_we_i, ex_we_i};
    assign jb_data = {mwb_result_i, exm_result_i, ex_result_i};

    bju_fwd_sel #(.XLEN(XLEN), .REGW(REGW), .NSRC(NBR)) u_fwd1 (
        .rs_i(rs1_i), .rd_i(br_rd), .we_i(br_we), .data_i(br_data),
        .rf_i(rf_rdata1_i), .opnd_o(opnd1_o), .hit_o(hit1)
    );

    bju_fwd_sel #(.XLEN(XLEN), .REGW(REGW), .NSRC(NBR)) u_fwd2 (
        .rs_i(rs2_i), .rd_i(br_rd), .we_i(br_we), .data_i(br_data),
        .rf_i(rf_rdata2_i), .opnd_o(opnd2_o), .hit_o(hit2)
    );

    bju_fwd_sel #(.XLEN(XLEN), .REGW(REGW), .NSRC(NJMP)) u_fwdj (
        .rs_i(rs1_i), .rd_i(jb_rd), .we_i(jb_we), .data_i(jb_data),
        .rf_i(rf_rdata1_i), .opnd_o(jbase), .hit_o(hitj)
    );

    bju_cond #(.XLEN(XLEN)) u_cond (
        .a_i(opnd1_o), .b_i(opnd2_o), .funct3_i(funct3_i),
        .is_branch_i(is_branch_i), .taken_o(taken)
    );

    bju_target #(.XLEN(XLEN)) u_tgt (
        .pc_i(pc_i), .imm_i(imm_i), .base_i(jbase),
        .jump_type_i(jump_type_i), .target_o(target_o)
    );

    assign redirect_o = taken || (jump_type_i != JT_NONE);

    always_comb begin
        if (!$isunknown({is_branch_i, jump_type_i, redirect_o, hit1, hitj, opnd1_o, jbase})) begin
            // R9
            redir_src_chk: assert (!(redirect_o && jump_type_i == JT_NONE) || is_branch_i)
                else $error("redirect without branch or jump");
            // R3
            jb_agree_chk: assert (hitj[0] || !hit1[0] || jbase == opnd1_o)
                else $error("jump base disagrees with branch operand");
        end
    end

endmodule

// File: tb/bju_resolve_bench.sv
module bju_resolve_bench;

    localparam int XLEN = 32;
    localparam int REGW = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [XLEN-1:0] pc, imm, rf1, rf2, exr, exmr, mwbr;
    logic [2:0]      f3;
    logic [1:0]      jt;
    logic            isbr, exwe, exmwe, mwbwe;
    logic [REGW-1:0] rs1, rs2, exrd, exmrd, mwbrd;
    logic [XLEN-1:0] target, op1, op2;
    logic            redirect;

    int checks = 0;
    int errors = 0;

    bju_resolve #(.XLEN(XLEN), .REGW(REGW)) u_bju_resolve (
        .pc_i(pc), .imm_i(imm), .funct3_i(f3), .jump_type_i(jt),
        .is_branch_i(isbr), .rs1_i(rs1), .rs2_i(rs2),
        .rf_rdata1_i(rf1), .rf_rdata2_i(rf2),
        .ex_rd_i(exrd), .ex_we_i(exwe), .ex_result_i(exr),
        .exm_rd_i(exmrd), .exm_we_i(exmwe), .exm_result_i(exmr),
        .mwb_rd_i(mwbrd), .mwb_we_i(mwbwe), .mwb_result_i(mwbr),
        .target_o(target), .redirect_o(redirect), .opnd1_o(op1), .opnd2_o(op2)
    );

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic cond_exp(input logic [2:0] c, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        case (c)
            3'b000:  return a == b;
            3'b001:  return a != b;
            3'b100:  return $signed(a) < $signed(b);
            3'b101:  return $signed(a) >= $signed(b);
            3'b110:  return a < b;
            3'b111:  return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [REGW-1:0] pick_rd(input int c);
        case (c)
            0:       return 5'd0;
            1:       return 5'd5;
            default: return 5'd9;
        endcase
    endfunction

    logic [XLEN-1:0] vals [6];

    initial begin
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;
        pc = '0; imm = '0; rf1 = '0; rf2 = '0; exr = '0; exmr = '0; mwbr = '0;
        f3 = '0; jt = '0; isbr = 1'b0; exwe = 1'b0; exmwe = 1'b0; mwbwe = 1'b0;
        rs1 = '0; rs2 = '0; exrd = '0; exmrd = '0; mwbrd = '0;
        @(posedge clk); #2;
        // R9 all-zero inputs
        chk("R9 idle redirect", {31'd0, redirect}, 32'd0);
        chk("R9 idle target", target, 32'd0);

        // Condition / jump-type sweep, no forwarding
        pc = 32'h0000_1000; imm = 32'hFFFF_FFF2; rs1 = 5'd3; rs2 = 5'd4;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                for (int c = 0; c < 8; c++) begin
                    for (int t = 0; t < 4; t++) begin
                        for (int b = 0; b < 2; b++) begin
                            logic tk;
                            logic [XLEN-1:0] et;
                            @(posedge clk);
                            rf1 = vals[i]; rf2 = vals[j]; f3 = 3'(c); jt = 2'(t); isbr = b[0];
                            #2;
                            tk = b[0] && cond_exp(3'(c), vals[i], vals[j]);
                            if (t == 2) et = (vals[i] + imm) & 32'hFFFF_FFFE;
                            else        et = pc + imm;
                            if (c == 2 || c == 3) chk("R8 reserved cond", {31'd0, redirect}, {31'd0, t != 0});
                            else if (t == 0)      chk("R7 condition", {31'd0, redirect}, {31'd0, tk});
                            else                  chk("R9 redirect", {31'd0, redirect}, {31'd0, tk || (t != 0)});
                            if (t == 1)      chk("R4 pcrel target", target, et);
                            else if (t == 2) chk("R5 indirect target", target, et);
                            else             chk("R6 default target", target, et);
                        end
                    end
                end
            end
        end

        // Forwarding sweep
        rs1 = 5'd5; rs2 = 5'd9; rf1 = 32'h1111_0001; rf2 = 32'h2222_0002;
        exr = 32'hE0E0_0011; exmr = 32'hAAAA_0023; mwbr = 32'hBBBB_0045;
        imm = 32'h0000_0100; jt = 2'd2; isbr = 1'b0; f3 = 3'b000;
        for (int a = 0; a < 6; a++) begin
            for (int m = 0; m < 6; m++) begin
                for (int w = 0; w < 6; w++) begin
                    logic [XLEN-1:0] e1, e2, eb;
                    logic h_ex1, h_m1, h_w1, h_m2, h_w2;
                    @(posedge clk);
                    exwe = a[0]; exrd = pick_rd(a / 2);
                    exmwe = m[0]; exmrd = pick_rd(m / 2);
                    mwbwe = w[0]; mwbrd = pick_rd(w / 2);
                    #2;
                    h_ex1 = exwe && exrd != 0 && exrd == rs1;
                    h_m1  = exmwe && exmrd != 0 && exmrd == rs1;
                    h_w1  = mwbwe && mwbrd != 0 && mwbrd == rs1;
                    h_m2  = exmwe && exmrd != 0 && exmrd == rs2;
                    h_w2  = mwbwe && mwbrd != 0 && mwbrd == rs2;
                    e1 = h_m1 ? exmr : (h_w1 ? mwbr : rf1);
                    e2 = h_m2 ? exmr : (h_w2 ? mwbr : rf2);
                    eb = h_ex1 ? exr : e1;
                    if (!(h_m1 || h_w1)) chk("R2 operand1 no forward", op1, rf1);
                    else                 chk("R1 operand1 priority", op1, e1);
                    if (!(h_m2 || h_w2)) chk("R2 operand2 no forward", op2, rf2);
                    else                 chk("R1 operand2 priority", op2, e2);
                    chk("R3 jump base priority", target, (eb + imm) & 32'hFFFF_FFFE);
                    chk("R9 jump redirect", {31'd0, redirect}, 32'd1);
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule